// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Per-Line Ownership

The block serves 32 general-purpose I/O lines through two mirrored register banks on a simple 32-bit register bus. Each bank, here called bank A and bank B, has the same set of registers: output, direction, input, interrupt level, interrupt flag, interrupt mask and input mirror. A per-line owner register decides which bank controls each line. A bank's output and direction values reach a pin only for the lines that bank owns. Flag reads and flag clears through a bank also act only on the lines it owns.

Pin inputs pass through a two-flop synchroniser. Each line then raises a level-sensitive interrupt flag whenever its synchronised input matches the polarity bit set in the owning bank's interrupt-level register. Software clears a flag by writing a 1 to it. Each bank drives its own interrupt output, which is the OR of that bank's flagged and unmasked lines. A shared enable register gates every output driver. Register contents map line n to bit n, and the bus carries them in big-endian byte order.

Top module: `gpio_dual_bank`

## Requirements
- R1: While reset is held and after it, every output, direction, level, mask, enable and owner bit is 0 and every flag is 0. gpio_oe_o, gpio_out_o and both interrupt outputs are 0 during reset.
- R2: Word offsets are fixed. Bank B uses 0x00 output, 0x04 direction, 0x08 input, 0x0C level, 0x10 flag, 0x14 mask and 0x18 mirror. Bank A uses the same layout at 0x20 to 0x38. The enable register is at 0x1C and the owner register is at 0x3C. A write takes effect at the clock edge on which req_i and we_i are high. A read returns data combinationally in the same cycle.
- R3: For line n, gpio_out_o[n] and the direction come from bank B when owner bit n is 1, and from bank A when it is 0.
- R4: gpio_oe_o[n] is 1 only when enable bit n is 1 and the owning bank's direction bit n is 1.
- R5: The input register of either bank shows all lines after two flops of synchronisation. A pin change applied before edge k becomes readable after edge k+1.
- R6: The input-mirror register of a bank shows the synchronised input of the lines that bank owns and 0 for the other lines.
- R7: A flag is set when the synchronised input equals the owning bank's level bit (1 means active high, 0 means active low). The flag stays set after the condition goes away. The flag rises one edge after the input becomes readable.
- R8: Writing 1 to a flag bit clears it, and writing 0 has no effect. A clear takes priority on its edge. A flag whose condition still holds is set again on the following edge.
- R9: A bank's flag register reads 0 for lines it does not own. A clear written through a bank does not affect lines owned by the other bank.
- R10: irq_b_o is the OR over the lines owned by bank B of flag AND bank B mask. irq_a_o is the same for bank A.
- R11: Register bit n is line n. On the bus, register byte k travels on byte lane 3-k, so bus bits 31:24 carry lines 7:0.
- R12: Reads of unmapped offsets (non-zero low two address bits, or offsets 0x40 and up) return 0. Writes to unmapped offsets, and writes to the input and mirror registers, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write enable (1 write, 0 read) |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data, big-endian byte order |
| rdata_o | output | 32 | Read data, big-endian byte order |
| gpio_in_i | input | 32 | Pin input levels (asynchronous) |
| gpio_out_o | output | 32 | Pin output values |
| gpio_oe_o | output | 32 | Pin output enables |
| irq_a_o | output | 1 | Bank A combined interrupt |
| irq_b_o | output | 1 | Bank B combined interrupt |

## Verification
The flag logic is exercised three ways. Active-high and active-low levels are driven with sparse and dense pin patterns, which separates the polarity handling from the latching. Patterns that drop the condition after it is set show whether flags stick. Patterns that keep the condition active across a clear show whether the clear takes priority and the flag re-arms on the next edge.

Owner values that split the lines unevenly between the banks reveal whether steering, flag visibility and clears respect ownership. A raw single-byte bus write shows the byte-lane order. After these directed cases, random writes across the whole map and random pin changes are compared against a cycle model in the bench.

// File: rtl/gpio_dual_bank_pkg.sv
package gpio_dual_bank_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [2:0] {
    REG_OUT    = 3'd0,
    REG_DIR    = 3'd1,
    REG_IN     = 3'd2,
    REG_LVL    = 3'd3,
    REG_FLAG   = 3'd4,
    REG_MASK   = 3'd5,
    REG_MIRROR = 3'd6,
    REG_SHARED = 3'd7
  } reg_sel_e;

  function automatic logic [BUS_W-1:0] swap_bytes(input logic [BUS_W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs import gpio_dual_bank_pkg::*; #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  reg_sel_e             sel_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] out_o,
  output logic [NUM_LINES-1:0] dir_o,
  output logic [NUM_LINES-1:0] lvl_o,
  output logic [NUM_LINES-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o  <= '0;
      dir_o  <= '0;
      lvl_o  <= '0;
      mask_o <= '0;
    end else if (wr_i) begin
      case (sel_i)
        REG_OUT:  out_o  <= wdata_i;
        REG_DIR:  dir_o  <= wdata_i;
        REG_LVL:  lvl_o  <= wdata_i;
        REG_MASK: mask_o <= wdata_i;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] in_sync_i,
  input  logic [NUM_LINES-1:0] lvl_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] flag_o
);
  logic [NUM_LINES-1:0] active;
  assign active = ~(in_sync_i ^ lvl_i);

  // clear wins on its edge; a live condition re-arms on the next one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else flag_o <= (flag_o | active) & ~clr_i;
  end
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank import gpio_dual_bank_pkg::*; #(
  parameter int NUM_LINES   = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BUS_W-1:0]     wdata_i,
  output logic [BUS_W-1:0]     rdata_o,
  input  logic [NUM_LINES-1:0] gpio_in_i,
  output logic [NUM_LINES-1:0] gpio_out_o,
  output logic [NUM_LINES-1:0] gpio_oe_o,
  output logic                 irq_a_o,
  output logic                 irq_b_o
);
  localparam int NB     = 2;
  localparam int BANK_B = 0;
  localparam int BANK_A = 1;

  logic                 mapped, wr, bank_idx;
  reg_sel_e             slot;
  logic [BUS_W-1:0]     wswap, rval;
  logic [NUM_LINES-1:0] wdat, owner_q, enable_q, in_sync, flag, lvl_sel, clr;
  logic [NUM_LINES-1:0] own_m [NB];
  logic [NUM_LINES-1:0] out_r [NB];
  logic [NUM_LINES-1:0] dir_r [NB];
  logic [NUM_LINES-1:0] lvl_r [NB];
  logic [NUM_LINES-1:0] mask_r [NB];

  assign mapped   = (addr_i[ADDR_W-1:6] == '0) && (addr_i[1:0] == 2'b00);
  assign bank_idx = addr_i[5];
  assign slot     = reg_sel_e'(addr_i[4:2]);
  assign wswap    = swap_bytes(wdata_i);
  assign wdat     = wswap[NUM_LINES-1:0];
  assign wr       = req_i && we_i && mapped;

  assign own_m[BANK_B] = owner_q;
  assign own_m[BANK_A] = ~owner_q;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    gpio_bank_regs #(.NUM_LINES(NUM_LINES)) u_regs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr && (bank_idx == 1'(b)) && (slot != REG_SHARED)),
      .sel_i  (slot),
      .wdata_i(wdat),
      .out_o  (out_r[b]),
      .dir_o  (dir_r[b]),
      .lvl_o  (lvl_r[b]),
      .mask_o (mask_r[b])
    );
  end

  // shared slot: enable in the B half, owner in the A half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      owner_q  <= '0;
    end else if (wr && slot == REG_SHARED) begin
      if (bank_idx) owner_q <= wdat;
      else enable_q <= wdat;
    end
  end

  gpio_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_in_i),
    .q_o   (in_sync)
  );

  assign lvl_sel = (owner_q & lvl_r[BANK_B]) | (~owner_q & lvl_r[BANK_A]);
  assign clr     = (wr && slot == REG_FLAG) ? (wdat & own_m[bank_idx]) : '0;

  gpio_irq_flags #(.NUM_LINES(NUM_LINES)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_sync_i(in_sync),
    .lvl_i    (lvl_sel),
    .clr_i    (clr),
    .flag_o   (flag)
  );

  assign gpio_out_o = (owner_q & out_r[BANK_B]) | (~owner_q & out_r[BANK_A]);
  assign gpio_oe_o  = enable_q & ((owner_q & dir_r[BANK_B]) | (~owner_q & dir_r[BANK_A]));
  assign irq_b_o    = |(flag & mask_r[BANK_B] & own_m[BANK_B]);
  assign irq_a_o    = |(flag & mask_r[BANK_A] & own_m[BANK_A]);

  always_comb begin
    rval = '0;
    case (slot)
      REG_OUT:    rval = BUS_W'(out_r[bank_idx]);
      REG_DIR:    rval = BUS_W'(dir_r[bank_idx]);
      REG_IN:     rval = BUS_W'(in_sync);
      REG_LVL:    rval = BUS_W'(lvl_r[bank_idx]);
      REG_FLAG:   rval = BUS_W'(flag & own_m[bank_idx]);
      REG_MASK:   rval = BUS_W'(mask_r[bank_idx]);
      REG_MIRROR: rval = BUS_W'(in_sync & own_m[bank_idx]);
      REG_SHARED: rval = bank_idx ? BUS_W'(owner_q) : BUS_W'(enable_q);
      default:    rval = '0;
    endcase
  end

  assign rdata_o = (req_i && !we_i && mapped) ? swap_bytes(rval) : '0;
endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk import gpio_dual_bank_pkg::*; #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [BUS_W-1:0]     wdata_i,
  input logic [BUS_W-1:0]     rdata_o,
  input logic [NUM_LINES-1:0] gpio_out_o,
  input logic [NUM_LINES-1:0] gpio_oe_o,
  input logic [NUM_LINES-1:0] flag,
  input logic [NUM_LINES-1:0] owner_q
);
  logic [BUS_W-1:0]     w_sw;
  logic [NUM_LINES-1:0] w_lines;
  logic                 unmapped;
  assign w_sw     = swap_bytes(wdata_i);
  assign w_lines  = w_sw[NUM_LINES-1:0];
  assign unmapped = (addr_i[1:0] != 2'b00) || (addr_i[ADDR_W-1:6] != '0);

  AST_OUT_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && we_i) |-> $stable(gpio_out_o)); // R3
  AST_OE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && we_i) |-> $stable(gpio_oe_o)); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && unmapped) |-> (rdata_o == '0)); // R12
  AST_CLEAR_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(8'h10)) |=> ((flag & $past(owner_q & w_lines)) == '0)); // R8
  AST_CLEAR_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(8'h30)) |=> ((flag & $past(~owner_q & w_lines)) == '0)); // R9
endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .gpio_out_o(gpio_out_o),
  .gpio_oe_o (gpio_oe_o),
  .flag      (flag),
  .owner_q   (owner_q)
);

// File: tb/test_gpio_dual_bank.sv
`timescale 1ns/1ps
module test_gpio_dual_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o, gpio_in_i = '0, gpio_out_o, gpio_oe_o;
  logic        irq_a_o, irq_b_o;
  int n_tests = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  gpio_dual_bank i_gpio_dual_bank (.*);

  // ---- reference model (index 0 = bank B, 1 = bank A)
  logic [31:0] m_out [2], m_dir [2], m_lvl [2], m_msk [2];
  logic [31:0] m_en, m_own, m_flag, m_s1, m_s2;

  function automatic logic [31:0] sw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
  function automatic logic [31:0] owned(input logic b);
    return b ? ~m_own : m_own;
  endfunction
  function automatic logic is_mapped(input logic [7:0] a);
    return (a[7:6] == 2'b00) && (a[1:0] == 2'b00);
  endfunction
  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic b = a[5];
    logic [31:0] v;
    if (!is_mapped(a)) return '0;
    case (a[4:2])
      3'd0: v = m_out[b];
      3'd1: v = m_dir[b];
      3'd2: v = m_s2;
      3'd3: v = m_lvl[b];
      3'd4: v = m_flag & owned(b);
      3'd5: v = m_msk[b];
      3'd6: v = m_s2 & owned(b);
      default: v = b ? m_own : m_en;
    endcase
    return sw(v);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++) begin
        m_out[b] <= '0; m_dir[b] <= '0; m_lvl[b] <= '0; m_msk[b] <= '0;
      end
      m_en <= '0; m_own <= '0; m_flag <= '0; m_s1 <= '0; m_s2 <= '0;
    end else begin
      logic [31:0] d, clr, sel;
      logic b;
      clr = '0;
      d = sw(wdata_i);
      b = addr_i[5];
      if (req_i && we_i && is_mapped(addr_i)) begin
        case (addr_i[4:2])
          3'd0: m_out[b] <= d;
          3'd1: m_dir[b] <= d;
          3'd3: m_lvl[b] <= d;
          3'd4: clr = d & owned(b);
          3'd5: m_msk[b] <= d;
          3'd7: if (b) m_own <= d; else m_en <= d;
          default: ;
        endcase
      end
      sel = (m_own & m_lvl[0]) | (~m_own & m_lvl[1]);
      m_flag <= (m_flag | ~(m_s2 ^ sel)) & ~clr;
      m_s1 <= gpio_in_i;
      m_s2 <= m_s1;
    end
  end

  // ---- check helpers
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #0.5;
    chk(tag, rdata_o, exp_read(a));
    req_i = 1'b0;
  endtask

  task automatic rd_lit(input string tag, input logic [7:0] a, input logic [31:0] exp_reg);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #0.5;
    chk(tag, sw(rdata_o), exp_reg);
    req_i = 1'b0;
  endtask

  task automatic wr_raw(input logic [7:0] a, input logic [31:0] bus);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = bus;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    wr_raw(a, sw(v));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk_ports(input string tag);
    logic [31:0] dsel;
    dsel = (m_own & m_dir[0]) | (~m_own & m_dir[1]);
    chk({tag, " out"}, gpio_out_o, (m_own & m_out[0]) | (~m_own & m_out[1]));
    chk({tag, " oe"}, gpio_oe_o, dsel & m_en);
    chk({tag, " irq_b"}, 32'(irq_b_o), 32'(|(m_flag & m_msk[0] & m_own)));
    chk({tag, " irq_a"}, 32'(irq_a_o), 32'(|(m_flag & m_msk[1] & ~m_own)));
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 16; i++) rd(tag, 8'(i * 4));
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0042));
    idle(3);
    // R1: reset state, read while reset held
    for (int i = 0; i < 16; i++) rd_lit("R1 reset reg", 8'(i * 4), 32'h0);
    chk("R1 reset out", gpio_out_o, '0);
    chk("R1 reset oe", gpio_oe_o, '0);
    chk("R1 reset irq", {30'b0, irq_a_o, irq_b_o}, '0);
    rst_ni = 1'b1;
    idle(4);

    // R7: active-high on bank A lines, clear stale flags
    wr(8'h2C, 32'hFFFF_FFFF);
    idle(3);
    wr(8'h30, 32'hFFFF_FFFF);
    rd_lit("R8 cleared after inactive", 8'h30, 32'h0);
    gpio_in_i = 32'h0000_00A5;
    @(posedge clk_i); @(negedge clk_i);
    rd_lit("R5 input after one edge", 8'h28, 32'h0);
    @(posedge clk_i); @(negedge clk_i);
    rd_lit("R5 input after two edges", 8'h28, 32'h0000_00A5);
    rd_lit("R7 flag not yet", 8'h30, 32'h0);
    @(posedge clk_i); @(negedge clk_i);
    rd_lit("R7 flag active high", 8'h30, 32'h0000_00A5);
    gpio_in_i = 32'h0;
    idle(4);
    rd_lit("R7 flag sticky", 8'h30, 32'h0000_00A5);
    wr(8'h30, 32'h0000_0005);
    rd_lit("R8 zero bits no effect", 8'h30, 32'h0000_00A0);
    gpio_in_i = 32'h0000_0080;
    idle(4);
    wr(8'h30, 32'h0000_0080);
    rd_lit("R8 clear wins", 8'h30, 32'h0000_0020);
    @(posedge clk_i); @(negedge clk_i);
    rd_lit("R8 rearm next edge", 8'h30, 32'h0000_00A0);

    // R10: mask selects bank A interrupt
    wr(8'h34, 32'h0000_0020);
    chk("R10 irq_a masked in", 32'(irq_a_o), 32'd1);
    chk("R10 irq_b idle", 32'(irq_b_o), 32'd0);
    wr(8'h34, 32'h0000_0001);
    chk("R10 irq_a masked out", 32'(irq_a_o), 32'd0);
    chk_ports("R10");

    // R9/R3: hand lines 7:4 to bank B (level 0 = active low there)
    wr(8'h3C, 32'h0000_00F0);
    idle(3);
    sweep("R9 after owner change");
    wr(8'h30, 32'h0000_00F0);
    rd("R9 A clear ignores B lines", 8'h10);
    rd("R9 A flag view", 8'h30);
    wr(8'h14, 32'h0000_0040);
    chk_ports("R10 bank B");

    // R3/R4: steering and enable gating
    wr(8'h00, 32'hF0F0_F0F0);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h20, 32'h0F0F_0F0F);
    wr(8'h24, 32'h0000_FFFF);
    chk("R4 enable off", gpio_oe_o, 32'h0);
    chk("R3 out steering", gpio_out_o, 32'h0F0F_0FFF);
    wr(8'h1C, 32'hFFFF_00FF);
    chk("R4 enable gating", gpio_oe_o, 32'h0000_00FF);
    chk_ports("R3");

    // R6: mirror shows owned lines only
    gpio_in_i = 32'hDEAD_BEEF;
    idle(3);
    rd_lit("R6 mirror B", 8'h18, 32'h0000_00E0);
    rd_lit("R6 mirror A", 8'h38, 32'hDEAD_BE0F);
    rd_lit("R5 input B full", 8'h08, 32'hDEAD_BEEF);

    // R11: byte-lane order
    wr(8'h3C, 32'h0);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr_raw(8'h20, 32'h0000_00FF);
    chk("R11 lane order", gpio_out_o, 32'hFF00_0000);

    // R12: unmapped and read-only slots
    rd_lit("R12 unaligned", 8'h21, 32'h0);
    rd_lit("R12 high offset", 8'h40, 32'h0);
    rd_lit("R12 far offset", 8'hFC, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h60, 32'h1234_5678);
    wr(8'h22, 32'h1234_5678);
    rd_lit("R12 input unchanged", 8'h28, 32'hDEAD_BEEF);
    chk("R12 out unchanged", gpio_out_o, 32'hFF00_0000);
    sweep("R12 sweep");

    // random phase: R2 map and all others against the model
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 5) begin
        logic [7:0] a = (op == 0) ? 8'($urandom) : 8'($urandom_range(0, 15) * 4);
        wr(a, $urandom);
      end else if (op < 7) begin
        gpio_in_i = $urandom;
        idle(1);
      end else begin
        idle(1);
      end
      chk_ports("R2 random ports");
      rd("R2 random read", 8'($urandom_range(0, 16) * 4));
      if (it % 50 == 0) sweep("R2 random sweep");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule